// File: doc/BRIEF.md
# DMA External Request Detector

This block sits between one DMA channel's external request pin and the channel's transfer engine. It brings the pin into the clock domain through a synchronizer and qualifies it by level or by edge, with a selectable polarity. It then raises a single pending request toward the engine. The pending request stays up until the engine reports that the matching transfer has started. A one-cycle acknowledge pulse follows. From acceptance of a request until that acknowledge has been issued, the pin is ignored.

In level mode an overrun option sets how many transfers a requester gets. The requester is expected to drop its pin when it sees the acknowledge for its last wanted transfer. With the option clear, the detector waits for the synchronizer to settle before it samples again, so the requester gets exactly the transfers it asked for. With the option set, it samples again at once and sees the stale level, so one extra transfer takes place. Requests are only accepted and held while every channel enable condition is true. If any condition fails, the pending request is dropped.

Top module: `dreq_detector`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, req_o and ack_o are 0.
- R2: With edge_mode_i=0 and pol_high_i=1 (high-level detection), a high synchronized pin accepted while idle and enabled raises req_o.
- R3: With edge_mode_i=0 and pol_high_i=0 (low-level detection), a low synchronized pin is treated as a request.
- R4: With edge_mode_i=1 and pol_high_i=1 (rising-edge detection), each 0-to-1 transition of the pin gives exactly one transfer, and a pin held high gives no more.
- R5: With edge_mode_i=1 and pol_high_i=0 (falling-edge detection), each 1-to-0 transition gives exactly one transfer.
- R6: Edges that arrive while a request is pending or being acknowledged are discarded, not queued.
- R7: In level mode with overrun_i=0, a requester that drops its pin on seeing its Nth acknowledge receives exactly N acknowledges.
- R8: In level mode with overrun_i=1, the same requester receives exactly N+1 acknowledges.
- R9: No request is raised while ch_en_i=0, dma_en_i=0, xfer_end_i=1, addr_err_i=1 or nmi_i=1.
- R10: If any enable condition fails while req_o is high, req_o falls in the next cycle and no acknowledge follows for that request.
- R11: ack_o is a single-cycle pulse in the cycle after req_o and xfer_start_i were both high with the channel enabled.
- R12: req_o stays high while enabled until xfer_start_i is seen, and is never high together with ack_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_pin_i | input | 1 | External request pin, asynchronous to clk_i |
| pol_high_i | input | 1 | 1: active high / rising, 0: active low / falling |
| edge_mode_i | input | 1 | 1: edge detection, 0: level detection |
| overrun_i | input | 1 | Level mode: 1 allows one transfer beyond the requests |
| ch_en_i | input | 1 | Channel enable |
| dma_en_i | input | 1 | Controller-wide enable |
| xfer_end_i | input | 1 | Channel transfer count exhausted |
| addr_err_i | input | 1 | Address error flag |
| nmi_i | input | 1 | Non-maskable interrupt flag |
| xfer_start_i | input | 1 | Engine starts the transfer for the pending request |
| req_o | output | 1 | Pending transfer request to the engine |
| ack_o | output | 1 | One-cycle acknowledge for the started transfer |

## Verification
The bench counts acknowledges for a level requester that drops its pin on a chosen acknowledge. Under one overrun setting it expects N, and under the other N+1. A detector that resamples too early or too late would give the count of the other mode. It creates a second edge while a request is parked with the engine stalled. A detector that queued that edge would produce a second acknowledge. It also drops each enable condition in turn, both while idle and while a request is pending. A design that latched the request through the disabled interval would resume it afterwards and emit a stray acknowledge.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_PEND = 2'd2,
    ST_ACK  = 2'd3
  } dreq_state_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pipe_q[STAGES-1];

  assign q_o      = pipe_q[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/dreq_detect.sv
module dreq_detect (
  input  logic cur_i,
  input  logic prev_i,
  input  logic pol_high_i,
  input  logic edge_mode_i,
  output logic hit_o
);
  logic lvl_hit, edg_hit;

  always_comb begin
    lvl_hit = pol_high_i ? cur_i : ~cur_i;
    edg_hit = pol_high_i ? (cur_i & ~prev_i) : (~cur_i & prev_i);
    hit_o   = edge_mode_i ? edg_hit : lvl_hit;
  end
endmodule

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
  import dreq_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic en_ok_i,
  input  logic level_mode_i,
  input  logic overrun_i,
  input  logic start_i,
  output logic req_o,
  output logic ack_o
);
  localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);

  dreq_state_e st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (!en_ok_i) begin
      st_n = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (hit_i) st_n = ST_PEND;
        ST_PEND: if (start_i) st_n = ST_ACK;
        ST_ACK: begin
          // exact-count level mode waits for the synchronizer to settle
          if (level_mode_i && !overrun_i) begin
            st_n  = ST_HOLD;
            cnt_n = CW'(HOLD_CYC - 1);
          end else begin
            st_n = ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) st_n = ST_IDLE;
          else             cnt_n = cnt_q - 1'b1;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end

  assign req_o = (st_q == ST_PEND);
  assign ack_o = (st_q == ST_ACK);
endmodule

// File: rtl/dreq_detector.sv
module dreq_detector #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_pin_i,
  input  logic pol_high_i,
  input  logic edge_mode_i,
  input  logic overrun_i,
  input  logic ch_en_i,
  input  logic dma_en_i,
  input  logic xfer_end_i,
  input  logic addr_err_i,
  input  logic nmi_i,
  input  logic xfer_start_i,
  output logic req_o,
  output logic ack_o
);
  logic pin_s, pin_prev, hit, en_ok;

  assign en_ok = ch_en_i & dma_en_i & ~xfer_end_i & ~addr_err_i & ~nmi_i;

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (req_pin_i),
    .q_o      (pin_s),
    .q_prev_o (pin_prev)
  );

  dreq_detect u_det (
    .cur_i       (pin_s),
    .prev_i      (pin_prev),
    .pol_high_i  (pol_high_i),
    .edge_mode_i (edge_mode_i),
    .hit_o       (hit)
  );

  dreq_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .en_ok_i      (en_ok),
    .level_mode_i (~edge_mode_i),
    .overrun_i    (overrun_i),
    .start_i      (xfer_start_i),
    .req_o        (req_o),
    .ack_o        (ack_o)
  );
endmodule

// File: rtl/dreq_detector_chk.sv
module dreq_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ch_en_i,
  input logic dma_en_i,
  input logic xfer_end_i,
  input logic addr_err_i,
  input logic nmi_i,
  input logic xfer_start_i,
  input logic req_o,
  input logic ack_o
);
  logic en_ok;
  assign en_ok = ch_en_i & dma_en_i & ~xfer_end_i & ~addr_err_i & ~nmi_i;

  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R11
  AST_START_GIVES_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && xfer_start_i && en_ok) |=> ack_o); // R11
  AST_ACK_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |=> !ack_o); // R11
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_ok |=> (!req_o && !ack_o)); // R9
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !xfer_start_i && en_ok) |=> req_o); // R12
  AST_REQ_ACK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && ack_o)); // R12
endmodule

bind dreq_detector dreq_detector_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ch_en_i      (ch_en_i),
  .dma_en_i     (dma_en_i),
  .xfer_end_i   (xfer_end_i),
  .addr_err_i   (addr_err_i),
  .nmi_i        (nmi_i),
  .xfer_start_i (xfer_start_i),
  .req_o        (req_o),
  .ack_o        (ack_o)
);

// File: tb/sim_dreq_detector.sv
`timescale 1ns/1ps
module sim_dreq_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, pol = 1'b1, edg = 1'b0, ovr = 1'b0;
  logic ch_en = 1'b0, dma_en = 1'b1, x_end = 1'b0, a_err = 1'b0, nmi = 1'b0;
  logic start = 1'b0;
  logic req, ack;

  int checks = 0, errors = 0, acks = 0, reqs = 0;
  logic req_prev = 1'b0;

  always #4 clk = ~clk;

  dreq_detector u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_pin_i(pin), .pol_high_i(pol),
    .edge_mode_i(edg), .overrun_i(ovr), .ch_en_i(ch_en), .dma_en_i(dma_en),
    .xfer_end_i(x_end), .addr_err_i(a_err), .nmi_i(nmi),
    .xfer_start_i(start), .req_o(req), .ack_o(ack)
  );

  // behavioural reference: pin history queue and a phase number
  bit hist[$] = '{0, 0, 0};  // [0]=newest stage, [1]=synced, [2]=previous synced
  int ph = 0;                // 0 idle, 1 settle, 2 waiting, 3 acknowledging
  int settle = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0}; ph = 0; settle = 0;
    end else begin
      bit en, lv, eg, hit;
      en  = ch_en && dma_en && !x_end && !a_err && !nmi;
      lv  = pol ? hist[1] : !hist[1];
      eg  = pol ? (hist[1] && !hist[2]) : (!hist[1] && hist[2]);
      hit = edg ? eg : lv;
      if (!en) ph = 0;
      else if (ph == 0) begin if (hit) ph = 2; end
      else if (ph == 2) begin if (start) ph = 3; end
      else if (ph == 3) begin
        if (!edg && !ovr) begin ph = 1; settle = 1; end else ph = 0;
      end else begin
        if (settle == 0) ph = 0; else settle--;
      end
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(req === (ph == 2), "R12 req_o vs model", req, ph == 2);
    chk(ack === (ph == 3), "R11 ack_o vs model", ack, ph == 3);
    if (ack) acks++;
    if (req && !req_prev) reqs++;
    req_prev = req;
  endtask

  task automatic quiesce(input logic p, input logic e, input logic o, input logic idle_pin);
    ch_en = 1'b0; start = 1'b0;
    pol = p; edg = e; ovr = o; pin = idle_pin;
    repeat (6) tick();
    acks = 0; reqs = 0;
    ch_en = 1'b1;
  endtask

  task automatic run_level(input logic p, input logic o, input int n, input int exp, input string tag);
    quiesce(p, 1'b0, o, ~p);
    start = 1'b1;
    pin = p;
    for (int k = 0; k < 400 && acks < n; k++) tick();
    pin = ~p;
    repeat (20) tick();
    chk(acks == exp, tag, acks, exp);
  endtask

  task automatic run_edge(input logic p, input int n, input string tag);
    quiesce(p, 1'b1, 1'b0, ~p);
    start = 1'b1;
    for (int k = 0; k < n; k++) begin
      pin = p;  repeat (8) tick();
      pin = ~p; repeat (8) tick();
    end
    chk(acks == n, tag, acks, n);
  endtask

  task automatic set_bad(input int i, input logic bad);
    case (i)
      0: ch_en  = ~bad;
      1: dma_en = ~bad;
      2: x_end  = bad;
      3: a_err  = bad;
      default: nmi = bad;
    endcase
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk(req === 1'b0 && ack === 1'b0, "R1 outputs in reset", {req, ack}, 0);
    rst_n = 1'b1;
    tick();
    chk(req === 1'b0 && ack === 1'b0, "R1 outputs after reset", {req, ack}, 0);

    // R2 / R7: high level, exact count
    run_level(1'b1, 1'b0, 3, 3, "R7 high level overrun off acks");
    chk(reqs == 3, "R2 high level requests", reqs, 3);
    // R8: high level, one extra
    run_level(1'b1, 1'b1, 3, 4, "R8 high level overrun on acks");
    // R3: low level
    run_level(1'b0, 1'b0, 2, 2, "R3 low level overrun off acks");
    run_level(1'b0, 1'b1, 1, 2, "R8 low level overrun on acks");

    // R4 / R5: edges
    run_edge(1'b1, 3, "R4 rising edge acks");
    run_edge(1'b0, 3, "R5 falling edge acks");
    quiesce(1'b1, 1'b1, 1'b0, 1'b0);
    start = 1'b1;
    pin = 1'b1;
    repeat (30) tick();
    chk(acks == 1, "R4 held high gives one transfer", acks, 1);

    // R6 / R11 / R12: second edge while stalled is discarded
    quiesce(1'b1, 1'b1, 1'b0, 1'b0);
    pin = 1'b1; repeat (5) tick();
    chk(req === 1'b1, "R12 request held while engine stalls", req, 1);
    pin = 1'b0; repeat (4) tick();
    pin = 1'b1; repeat (6) tick();
    chk(req === 1'b1, "R12 request still held", req, 1);
    start = 1'b1;
    tick();
    chk(ack === 1'b1, "R11 ack follows start", ack, 1);
    tick();
    chk(ack === 1'b0, "R11 ack lasts one cycle", ack, 0);
    repeat (20) tick();
    chk(acks == 1, "R6 blanked edge discarded", acks, 1);

    // R9: each enable condition blocks requests
    for (int i = 0; i < 5; i++) begin
      quiesce(1'b1, 1'b0, 1'b0, 1'b0);
      set_bad(i, 1'b1);
      start = 1'b1; pin = 1'b1;
      repeat (15) tick();
      chk(reqs == 0 && acks == 0, "R9 disabled gives no request", reqs + acks, 0);
      set_bad(i, 1'b0);
      pin = 1'b0;
    end

    // R10: enable drop clears pending request
    for (int i = 0; i < 5; i++) begin
      quiesce(1'b1, 1'b1, 1'b0, 1'b0);
      pin = 1'b1; repeat (5) tick();
      chk(req === 1'b1, "R10 request pending before drop", req, 1);
      set_bad(i, 1'b1);
      tick();
      chk(req === 1'b0, "R10 request cleared on drop", req, 0);
      set_bad(i, 1'b0);
      start = 1'b1;
      repeat (10) tick();
      chk(acks == 0, "R10 no ack after cleared request", acks, 0);
      pin = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule